// File: doc/BRIEF.md
# Interleaved Multi-Bank Word Memory

This block sits in front of a vector load/store path and spreads consecutive 64-bit words over a set of independent memory banks. Each bank takes a fixed number of cycles to complete an access. The requester can offer at most one element address per cycle. The block picks the bank from the address and keeps a busy timer for every bank. When the requester targets a bank that is still working, the block holds it off with `req_ready`.

Read data comes back on a single response port, at most one word per cycle. Words return in the same order in which the reads were accepted. A small queue of bank indices, filled at acceptance, selects which bank's completed word is presented next. Writes occupy their bank for the same busy time and store the word when they complete. Writes never produce a response. The bank arrays are not cleared by reset. The requester fills them through ordinary writes.

Top module: `ilv_bank_mem`

## Requirements
- R1: The bank index is taken from the address bits just above the byte offset of a word. With the defaults this is bank = `req_addr[5:3]` and row = `req_addr[11:6]`, so consecutive 64-bit words land in consecutive banks.
- R2: While reset is asserted and right after it, every bank is idle: `req_ready` is 1 for any address and `rsp_valid` is 0. Reads that were in flight when reset was asserted never return.
- R3: An access is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its bank then reports busy for exactly BUSY_CYCLES (6) cycles. A later access to the same bank is accepted no earlier than BUSY_CYCLES+1 edges after the earlier one.
- R4: Accesses to banks that are idle are accepted on back-to-back edges without stalls. At most one bank starts an access per cycle.
- R5: The word for an accepted read is presented with `rsp_valid`=1 during the cycle that follows the edge BUSY_CYCLES edges after acceptance. It is held for exactly one cycle.
- R6: Read responses leave in acceptance order, at most one per cycle. At most NUM_BANKS reads are outstanding.
- R7: A write stores `req_wdata` in the addressed word, where later reads see it, and it produces no response.
- R8: An access to a busy bank is not accepted. While the requester holds it, it is accepted on the first edge at which that bank is idle. A bank is never restarted while busy.
- R9: The three byte-offset bits `req_addr[2:0]` have no effect on which word is accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester offers an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address of the element |
| req_wdata | input | WORD_W (64) | Write data |
| req_ready | output | 1 | The addressed bank is idle, so the offer is accepted on this edge |
| rsp_valid | output | 1 | A read word is presented this cycle |
| rsp_data | output | WORD_W (64) | Read word, in acceptance order |

## Verification
The bench uses the default build: 8 banks, a busy time of 6 cycles, 64-bit words and a 12-bit byte address, which gives 64 rows per bank. Every one of the 512 words is written and read back, so the whole bank and row decode is covered. Same-bank strides reach the full 6-cycle stall, and a stride of two words reaches a partial 3-cycle stall. A reset issued while a read is pending shows that pending responses are dropped and that every bank starts idle.

// File: rtl/ilv_mem_pkg.sv
`timescale 1ns/1ps
package ilv_mem_pkg;

  // Kind of access held by a bank while it is busy.
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;

  // Cycles a bank must wait, counted from acceptance, before the same bank
  // can take a new access (busy window plus the freeing edge).
  function automatic int unsigned reuse_gap(input int unsigned busy_cycles);
    return busy_cycles + 1;
  endfunction

endpackage

// File: rtl/ilv_bank_unit.sv
`timescale 1ns/1ps
module ilv_bank_unit
  import ilv_mem_pkg::*;
#(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned ROW_W       = 6,
  parameter int unsigned BUSY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << ROW_W;
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  acc_kind_e         kind_q;
  logic [ROW_W-1:0]  row_q;
  logic [WORD_W-1:0] wdata_q;
  logic              done_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic              finish;

  // The access completes on the edge that takes the counter from 1 to 0.
  assign finish = (cnt_q == CNT_W'(1));
  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;
  assign rdata_o = rdata_q;

  // Busy timer: loaded at acceptance, runs down to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(BUSY_CYCLES);
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // Address, kind and data are latched when the access begins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= ACC_READ;
      row_q   <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      kind_q  <= write_i ? ACC_WRITE : ACC_READ;
      row_q   <= row_i;
      wdata_q <= wdata_i;
    end
  end

  // Completed-read flag, cleared when the return stage takes the word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (finish && kind_q == ACC_READ) begin
      done_q <= 1'b1;
    end else if (take_i) begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (finish && kind_q == ACC_READ) begin
      rdata_q <= mem_q[row_q];
    end
  end

  // Storage array: contents survive reset.
  always_ff @(posedge clk) begin
    if (finish && kind_q == ACC_WRITE) begin
      mem_q[row_q] <= wdata_q;
    end
  end

endmodule

// File: rtl/ilv_order_fifo.sv
`timescale 1ns/1ps
module ilv_order_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q;
  logic [PTR_W-1:0] rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign head_o  = slot_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_next(wr_q);
      if (pop_i)  rd_q <= ptr_next(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) slot_q[wr_q] <= idx_i;
  end

endmodule

// File: rtl/ilv_return_sel.sv
`timescale 1ns/1ps
module ilv_return_sel #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [IDX_W-1:0]     head_i,
  input  logic                 empty_i,
  input  logic [NUM_BANKS-1:0] done_i,
  input  logic [WORD_W-1:0]    rdata_i [NUM_BANKS],
  output logic                 rsp_valid_o,
  output logic [WORD_W-1:0]    rsp_data_o,
  output logic [NUM_BANKS-1:0] take_o
);

  // Only the oldest outstanding read may leave, which keeps acceptance order.
  assign rsp_valid_o = !empty_i && done_i[head_i];
  assign rsp_data_o  = rdata_i[head_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_take
    assign take_o[b] = rsp_valid_o && (head_i == IDX_W'(b));
  end

endmodule

// File: rtl/ilv_bank_mem.sv
`timescale 1ns/1ps
module ilv_bank_mem #(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned BUSY_CYCLES = 6,
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);

  localparam int unsigned OFF_W  = $clog2(WORD_W / 8);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned ROW_W  = ADDR_W - OFF_W - BANK_W;
  localparam int unsigned QCNT_W = $clog2(NUM_BANKS + 1);

  // Address split: byte offset | bank | row.
  function automatic logic [BANK_W-1:0] addr_bank(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] addr_row(input logic [ADDR_W-1:0] a);
    return a[OFF_W + BANK_W +: ROW_W];
  endfunction

  logic                 unused_lane;
  logic [BANK_W-1:0]    acc_bank;
  logic [ROW_W-1:0]     acc_row;
  logic                 accept;
  logic [NUM_BANKS-1:0] bank_start;
  logic [NUM_BANKS-1:0] bank_busy;
  logic [NUM_BANKS-1:0] bank_done;
  logic [NUM_BANKS-1:0] bank_take;
  logic [WORD_W-1:0]    bank_rdata [NUM_BANKS];
  logic [BANK_W-1:0]    q_head;
  logic                 q_empty;
  logic [QCNT_W-1:0]    q_count;

  assign unused_lane = ^req_addr[OFF_W-1:0];
  assign acc_bank    = addr_bank(req_addr);
  assign acc_row     = addr_row(req_addr);
  assign req_ready   = !bank_busy[acc_bank];
  assign accept      = req_valid && req_ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_start[b] = accept && (acc_bank == BANK_W'(b));

    ilv_bank_unit #(
      .WORD_W     (WORD_W),
      .ROW_W      (ROW_W),
      .BUSY_CYCLES(BUSY_CYCLES)
    ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(bank_start[b]),
      .write_i(req_write),
      .row_i  (acc_row),
      .wdata_i(req_wdata),
      .take_i (bank_take[b]),
      .busy_o (bank_busy[b]),
      .done_o (bank_done[b]),
      .rdata_o(bank_rdata[b])
    );
  end

  ilv_order_fifo #(
    .DEPTH(NUM_BANKS),
    .IDX_W(BANK_W),
    .CNT_W(QCNT_W)
  ) order_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (accept && !req_write),
    .idx_i  (acc_bank),
    .pop_i  (rsp_valid),
    .head_o (q_head),
    .empty_o(q_empty),
    .count_o(q_count)
  );

  ilv_return_sel #(
    .NUM_BANKS(NUM_BANKS),
    .WORD_W   (WORD_W),
    .IDX_W    (BANK_W)
  ) ret_i (
    .head_i     (q_head),
    .empty_i    (q_empty),
    .done_i     (bank_done),
    .rdata_i    (bank_rdata),
    .rsp_valid_o(rsp_valid),
    .rsp_data_o (rsp_data),
    .take_o     (bank_take)
  );

endmodule

// File: rtl/ilv_bank_mem_chk.sv
`timescale 1ns/1ps
module ilv_bank_mem_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned QCNT_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic [BANK_W-1:0]    acc_bank,
  input logic [NUM_BANKS-1:0] bank_start,
  input logic [NUM_BANKS-1:0] bank_busy,
  input logic [NUM_BANKS-1:0] bank_done,
  input logic                 rsp_valid,
  input logic [QCNT_W-1:0]    q_count
);

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bank_busy[$past(acc_bank)]);

  assert_no_restart_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_start & bank_busy) == '0);

  assert_one_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_start));

  assert_one_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_done));

  assert_done_goes_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_done != '0) |-> rsp_valid);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCNT_W'(NUM_BANKS));

endmodule

bind ilv_bank_mem ilv_bank_mem_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .QCNT_W   (QCNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .acc_bank  (acc_bank),
  .bank_start(bank_start),
  .bank_busy (bank_busy),
  .bank_done (bank_done),
  .rsp_valid (rsp_valid),
  .q_count   (q_count)
);

// File: tb/ilv_bank_mem_tb_top.sv
`timescale 1ns/1ps
module ilv_bank_mem_tb_top;

  localparam int BUSY  = 6;
  localparam int WORDS = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  always #2.5 clk = ~clk;

  ilv_bank_mem dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [63:0] shadow [WORDS];
  int          next_ok [8];
  logic [63:0] exp_data [1024];
  int          exp_due [1024];
  int          wr_ptr = 0;
  int          rd_ptr = 0;
  int          reads_acc = 0;
  int          cancelled = 0;
  int          resp_seen = 0;

  // Table: bit 12 = write, bits 11:0 = byte address.
  localparam logic [12:0] TBL [24] = '{
    13'h0000, 13'h0008, 13'h0010, 13'h0018, 13'h0020, 13'h0028, 13'h0030, 13'h0038,
    13'h0000, 13'h0040, 13'h0080, 13'h00C0,
    13'h0100, 13'h0110, 13'h0120, 13'h0130, 13'h0140,
    13'h1208, 13'h020F, 13'h13F8, 13'h03F8,
    13'h0005, 13'h01FF, 13'h0038
  };

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pat(input int w);
    return 64'hC0DE_0000_0000_0000 ^ (64'(w) * 64'h0001_0003_0007_0011);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Response monitor: order, data and timing (R5 R6), nothing extra (R7).
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      cancelled += wr_ptr - rd_ptr;
      rd_ptr = wr_ptr;
    end else if (rsp_valid) begin
      resp_seen++;
      if (rd_ptr == wr_ptr) begin
        check(1'b0, "R7 unexpected response", rsp_data, 64'h0);
      end else begin
        check(rsp_data == exp_data[rd_ptr], "R5 R6 data order", rsp_data, exp_data[rd_ptr]);
        check(cyc == exp_due[rd_ptr], "R5 return cycle", 64'(cyc), 64'(exp_due[rd_ptr]));
        rd_ptr++;
      end
    end else if (rd_ptr != wr_ptr && exp_due[rd_ptr] <= cyc) begin
      check(1'b0, "R5 missing response", 64'(cyc), 64'(exp_due[rd_ptr]));
      rd_ptr++;
    end
  end

  // Offer one access, hold it until accepted and compare the acceptance edge
  // with the bank-occupancy model (bank = addr[5:3], word = addr[11:3]).
  task automatic issue(input logic wr, input logic [11:0] addr, input logic [63:0] data,
                       input string tag);
    int first;
    int acc;
    int want;
    int b;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = data;
    first = cyc + 1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc  = cyc + 1;
    b    = int'(addr[5:3]);
    want = (next_ok[b] > first) ? next_ok[b] : first;
    check(acc == want, tag, 64'(acc), 64'(want));
    next_ok[b] = acc + BUSY + 1;
    if (wr) begin
      shadow[addr[11:3]] = data;
    end else begin
      exp_data[wr_ptr] = shadow[addr[11:3]];
      exp_due[wr_ptr]  = acc + BUSY;
      wr_ptr++;
      reads_acc++;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < 8; b++) next_ok[b] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R2: idle state under reset.
    check(req_ready == 1'b1, "R2 ready in reset", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R2 no response in reset", 64'(rsp_valid), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill every word with unit stride: no stalls (R1 R4 R7).
    for (int w = 0; w < WORDS; w++) begin
      issue(1'b1, 12'(w * 8), pat(w), "R1 R4 R7 fill accept");
    end

    // Table walk: strides, same-bank stalls, offset bits, write then read.
    for (int i = 0; i < 24; i++) begin
      issue(TBL[i][12], TBL[i][11:0], 64'hFACE_0000_0000_0000 + 64'(i),
            "R1 R3 R4 R8 R9 table accept");
    end
    repeat (BUSY + 3) @(posedge clk);

    // Whole array read back in unit stride.
    for (int w = 0; w < WORDS; w++) begin
      issue(1'b0, 12'(w * 8 + (w % 8)), 64'h0, "R4 R9 readback accept");
    end
    repeat (BUSY + 3) @(posedge clk);

    // Same bank back to back: exactly 6-cycle busy window (R3 R8).
    issue(1'b0, 12'h048, 64'h0, "R3 first");
    issue(1'b0, 12'h088, 64'h0, "R3 R8 second same bank");

    // Reset while a read is in flight (R2).
    issue(1'b0, 12'h000, 64'h0, "R2 pre-reset read");
    @(negedge clk);
    rst_n = 1'b0;
    req_addr = 12'h000;
    for (int b = 0; b < 8; b++) next_ok[b] = 0;
    #1;
    check(req_ready == 1'b1, "R2 bank idle after reset", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R2 response dropped", 64'(rsp_valid), 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    issue(1'b0, 12'h000, 64'h0, "R2 no stall after reset");
    repeat (BUSY + 6) @(posedge clk);

    #1;
    check(rd_ptr == wr_ptr, "R5 all reads returned", 64'(rd_ptr), 64'(wr_ptr));
    check(resp_seen == reads_acc - cancelled, "R7 responses only for reads",
          64'(resp_seen), 64'(reads_acc - cancelled));

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule